// File: doc/BRIEF.md
# Exception Control Register Unit

This block keeps the exception state of a processor core in three special registers. The first is a saved program counter: the address of the instruction that was running when the exception arrived. The second is a pending-source register with one sticky bit per exception source. The third is a single interrupt-enable bit. The control sequencer drives the block with four kinds of event:

- a take-exception strobe with a source code;
- a move-to or move-from strobe with a register select;
- a return strobe;
- the instruction-fetch marker that gates external interrupt requests.

On an exception the block saves the current PC and marks the source bit as pending. It turns interrupts off and asks the sequencer to load a fixed handler address, all in the same cycle. On a return it offers the saved PC as the next PC and turns interrupts back on. Software reads the registers through a combinational read port and writes them through the move-to strobe. The pending bits are cleared only by such a write.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While reset is active and right after it, the saved PC and the pending bits are zero, interrupts are disabled, and `pc_load` is low.
- R2: When `exc_take` is high, `pc_load` is high and `pc_next` equals the parameter `VECTOR` (default 0x8000) in that cycle. After the clock edge, the saved PC holds `cur_pc` and interrupt enable is 0.
- R3: An exception sets pending bit `exc_code` (bit index = code). Bits that were already set stay set.
- R4: `rd_data` shows the register chosen by `csr_sel`: 0 gives the saved PC, 1 gives the pending bits zero-extended, 2 gives the enable bit in bit 0, and 3 gives zero.
- R5: A move-to (`mt_en`) writes `wr_data` into the selected register: all 32 bits for select 0, the low `CAUSE_N` bits for select 1, and bit 0 for select 2. The new value is visible on the next cycle. The pending bits change only through such a write or through an exception.
- R6: When `rti` is high, `pc_load` is high and `pc_next` equals the saved PC in that cycle. After the edge, interrupt enable is 1.
- R7: If `exc_take` falls in the same cycle as `mt_en` or `rti`, only the exception update takes effect, and `pc_next` is `VECTOR`.
- R8: `irq_pending` is high exactly when `irq_req` and `fetch` are both high and interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_pc | input | 32 | PC of the instruction now executing |
| exc_take | input | 1 | Take an exception this cycle |
| exc_code | input | $clog2(CAUSE_N) | Source index of the exception |
| irq_req | input | 1 | External interrupt request |
| fetch | input | 1 | Instruction-fetch cycle marker |
| mt_en | input | 1 | Move-to strobe |
| csr_sel | input | 2 | Special-register select (0 saved PC, 1 pending, 2 enable) |
| wr_data | input | 32 | Move-to write data |
| rti | input | 1 | Return-from-interrupt strobe |
| rd_data | output | 32 | Move-from read data |
| pc_next | output | 32 | PC to load |
| pc_load | output | 1 | Load `pc_next` into the PC |
| irq_pending | output | 1 | Masked interrupt to service at this fetch |

## Verification
Two operations can land in the same cycle: an exception entry, and either a software move-to or a return. The bench forces both collisions. In one cycle it pairs an exception with a move-to aimed at the saved PC. In another it pairs an exception with a return. It then judges the result in three places: the `pc_next` value shown during the collision cycle, and the saved PC and enable bit read back afterwards. The bench also reads the pending bits after two different sources fire, to confirm the bits accumulate.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_EPC   = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EI    = 2'd2,
    SEL_NONE  = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int CAUSE_N = 8,
  localparam int CODE_W = (CAUSE_N > 1) ? $clog2(CAUSE_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CODE_W-1:0]  code,
  input  logic               wr_en,
  input  logic [CAUSE_N-1:0] wr_val,
  output logic [CAUSE_N-1:0] cause
);
  logic [CAUSE_N-1:0] cause_q, cause_d, src_dec;
  logic               cause_en;

  always_comb begin
    for (int i = 0; i < CAUSE_N; i++) src_dec[i] = (code == CODE_W'(i));
  end

  always_comb begin
    cause_en = take | wr_en;
    cause_d  = cause_q;
    if (take)       cause_d = cause_q | src_dec;
    else if (wr_en) cause_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause = cause_q;

  // R3
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (((cause_q & $past(cause_q)) == $past(cause_q)) && (cause_q[$past(code)] == 1'b1)));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !wr_en) |=> $stable(cause_q));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic              ret,
  input  logic              wr_epc,
  input  logic              wr_ei,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] epc,
  output logic              ei
);
  logic [DATA_W-1:0] epc_q, epc_d;
  logic              ei_q, ei_d;
  logic              epc_en, ei_en;

  always_comb begin
    epc_en = take | wr_epc;
    epc_d  = take ? cur_pc : wr_val;
  end

  always_comb begin
    ei_en = take | ret | wr_ei;
    if (take)     ei_d = 1'b0;
    else if (ret) ei_d = 1'b1;
    else          ei_d = wr_val[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ei_q <= 1'b0;
    else if (ei_en) ei_q <= ei_d;
  end

  assign epc = epc_q;
  assign ei  = ei_q;

  // R2
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(cur_pc)) && !ei_q);

  // R6
  ret_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> ei_q);
endmodule

// File: rtl/exc_read_mux.sv
module exc_read_mux
  import exc_pkg::*;
#(
  parameter int CAUSE_N = 8
) (
  input  logic [1:0]         sel,
  input  logic [DATA_W-1:0]  epc,
  input  logic [CAUSE_N-1:0] cause,
  input  logic               ei,
  output logic [DATA_W-1:0]  rd
);
  logic [DATA_W-1:0] cause_ext, ei_ext;

  generate
    if (CAUSE_N < DATA_W) begin : g_pad
      assign cause_ext = {{(DATA_W-CAUSE_N){1'b0}}, cause};
    end else begin : g_full
      assign cause_ext = cause[DATA_W-1:0];
    end
  endgenerate

  assign ei_ext = {{(DATA_W-1){1'b0}}, ei};

  always_comb begin
    unique case (csr_sel_e'(sel))
      SEL_EPC:   rd = epc;
      SEL_CAUSE: rd = cause_ext;
      SEL_EI:    rd = ei_ext;
      default:   rd = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int          CAUSE_N = 8,
  parameter logic [31:0] VECTOR  = 32'h0000_8000,
  localparam int CODE_W = (CAUSE_N > 1) ? $clog2(CAUSE_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cur_pc,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              fetch,
  input  logic              mt_en,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       wr_data,
  input  logic              rti,
  output logic [31:0]       rd_data,
  output logic [31:0]       pc_next,
  output logic              pc_load,
  output logic              irq_pending
);
  logic               rst_s_n;
  logic [DATA_W-1:0]  epc;
  logic [CAUSE_N-1:0] cause;
  logic               ei;
  logic               wr_epc, wr_cause, wr_ei, ret_ok;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_an(rst_n), .rst_sn(rst_s_n)
  );

  // Exception entry has priority over software writes and return.
  always_comb begin
    wr_epc   = mt_en && !exc_take && (csr_sel == SEL_EPC);
    wr_cause = mt_en && !exc_take && (csr_sel == SEL_CAUSE);
    wr_ei    = mt_en && !exc_take && (csr_sel == SEL_EI);
    ret_ok   = rti && !exc_take;
  end

  exc_cause_reg #(.CAUSE_N(CAUSE_N)) u_cause (
    .clk(clk), .rst_n(rst_s_n), .take(exc_take), .code(exc_code),
    .wr_en(wr_cause), .wr_val(wr_data[CAUSE_N-1:0]), .cause(cause)
  );

  exc_state_regs u_state (
    .clk(clk), .rst_n(rst_s_n), .take(exc_take), .cur_pc(cur_pc),
    .ret(ret_ok), .wr_epc(wr_epc), .wr_ei(wr_ei), .wr_val(wr_data),
    .epc(epc), .ei(ei)
  );

  exc_read_mux #(.CAUSE_N(CAUSE_N)) u_rd (
    .sel(csr_sel), .epc(epc), .cause(cause), .ei(ei), .rd(rd_data)
  );

  always_comb begin
    pc_load = exc_take | rti;
    pc_next = exc_take ? VECTOR : epc;
  end

  assign irq_pending = irq_req & fetch & ei;

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_pending |-> (ei && fetch && irq_req));

  // R7
  exc_priority_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (exc_take && rti) |=> !ei);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> (epc == '0) && (cause == '0) && !ei);
endmodule

// File: tb/test_exc_ctrl_unit.sv
module test_exc_ctrl_unit;
  localparam int CAUSE_N = 8;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc, wr_data;
  logic        exc_take, irq_req, fetch, mt_en, rti;
  logic [2:0]  exc_code;
  logic [1:0]  csr_sel;
  logic [31:0] rd_data, pc_next;
  logic        pc_load, irq_pending;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  exc_ctrl_unit #(.CAUSE_N(CAUSE_N), .VECTOR(32'h0000_8000)) i_exc_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_take(exc_take),
    .exc_code(exc_code), .irq_req(irq_req), .fetch(fetch), .mt_en(mt_en),
    .csr_sel(csr_sel), .wr_data(wr_data), .rti(rti), .rd_data(rd_data),
    .pc_next(pc_next), .pc_load(pc_load), .irq_pending(irq_pending)
  );

  // fields: take, code[3], rti, mt, sel[2], data[16], pc[16], exp_load, exp_val[16]
  localparam logic [56:0] VEC [NV] = '{
    {1'b0,3'd0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b0,16'h0000}, // 0  R1 pending zero
    {1'b1,3'd2,1'b0,1'b0,2'd0,16'h0000,16'h0100,1'b1,16'h8000}, // 1  R2 entry vector
    {1'b0,3'd0,1'b0,1'b0,2'd0,16'h0000,16'h0000,1'b0,16'h0100}, // 2  R2 saved PC, R4 sel 0
    {1'b0,3'd0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b0,16'h0004}, // 3  R3 bit 2
    {1'b1,3'd5,1'b0,1'b0,2'd0,16'h0000,16'h0200,1'b1,16'h8000}, // 4  R2 second entry
    {1'b0,3'd0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b0,16'h0024}, // 5  R3 sticky
    {1'b0,3'd0,1'b0,1'b0,2'd2,16'h0000,16'h0000,1'b0,16'h0000}, // 6  R2 EI off
    {1'b0,3'd0,1'b1,1'b0,2'd0,16'h0000,16'h0000,1'b1,16'h0200}, // 7  R6 return PC
    {1'b0,3'd0,1'b0,1'b0,2'd2,16'h0000,16'h0000,1'b0,16'h0001}, // 8  R6 EI on
    {1'b0,3'd0,1'b0,1'b1,2'd1,16'h0020,16'h0000,1'b0,16'h0024}, // 9  R5 clear bit 2
    {1'b0,3'd0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b0,16'h0020}, // 10 R5 written
    {1'b0,3'd0,1'b0,1'b1,2'd0,16'h1234,16'h0000,1'b0,16'h0200}, // 11 R5 write EPC
    {1'b0,3'd0,1'b0,1'b0,2'd0,16'h0000,16'h0000,1'b0,16'h1234}, // 12 R5 EPC written
    {1'b1,3'd0,1'b0,1'b1,2'd0,16'hBEEF,16'h0300,1'b1,16'h8000}, // 13 R7 entry vs move-to
    {1'b0,3'd0,1'b0,1'b0,2'd0,16'h0000,16'h0000,1'b0,16'h0300}, // 14 R7 entry wins
    {1'b0,3'd0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b0,16'h0021}, // 15 R3 bit 0 added
    {1'b0,3'd0,1'b0,1'b0,2'd3,16'h0000,16'h0000,1'b0,16'h0000}, // 16 R4 unused select
    {1'b0,3'd0,1'b1,1'b0,2'd0,16'h0000,16'h0000,1'b1,16'h0300}, // 17 R6 return again
    {1'b1,3'd1,1'b1,1'b0,2'd0,16'h0000,16'h0400,1'b1,16'h8000}, // 18 R7 entry vs return
    {1'b0,3'd0,1'b0,1'b0,2'd2,16'h0000,16'h0000,1'b0,16'h0000}, // 19 R7 EI stays off
    {1'b0,3'd0,1'b0,1'b1,2'd2,16'h0001,16'h0000,1'b0,16'h0000}, // 20 R5 write EI
    {1'b0,3'd0,1'b0,1'b0,2'd2,16'h0000,16'h0000,1'b0,16'h0001}  // 21 R5 EI written
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exc_take = 0; exc_code = '0; rti = 0; mt_en = 0; csr_sel = 2'd0;
    wr_data = '0; cur_pc = '0; irq_req = 0; fetch = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 epc", rd_data, 32'h0);
    chk("R1 pc_load", {31'b0, pc_load}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    csr_sel = 2'd2; #1;
    chk("R1 ei", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      exc_take = VEC[i][56];
      exc_code = VEC[i][55:53];
      rti      = VEC[i][52];
      mt_en    = VEC[i][51];
      csr_sel  = VEC[i][50:49];
      wr_data  = {16'h0, VEC[i][48:33]};
      cur_pc   = {16'h0, VEC[i][32:17]};
      #1;
      chk($sformatf("R2/R7 vec%0d load", i), {31'b0, pc_load}, {31'b0, VEC[i][16]});
      if (VEC[i][16]) chk($sformatf("R2/R6 vec%0d pc_next", i), pc_next, {16'h0, VEC[i][15:0]});
      else            chk($sformatf("R4/R5 vec%0d rd", i), rd_data, {16'h0, VEC[i][15:0]});
    end

    // R4 upper bits of a wide move-to into EI/cause are not kept
    @(negedge clk); idle();
    mt_en = 1; csr_sel = 2'd1; wr_data = 32'hFFFF_FF81;
    @(negedge clk); idle(); csr_sel = 2'd1; #1;
    chk("R4 cause zero-extended", rd_data, 32'h0000_0081);

    // R8 interrupt gating (EI is 1 here)
    irq_req = 1; fetch = 1; #1;
    chk("R8 pending at fetch", {31'b0, irq_pending}, 32'h1);
    fetch = 0; #1;
    chk("R8 no fetch", {31'b0, irq_pending}, 32'h0);
    @(negedge clk);
    irq_req = 0; mt_en = 1; csr_sel = 2'd2; wr_data = 32'h0;
    @(negedge clk); idle();
    irq_req = 1; fetch = 1; #1;
    chk("R8 masked", {31'b0, irq_pending}, 32'h0);

    // R1 reset clears state mid-run
    @(negedge clk); idle();
    rst_n = 0; #1;
    csr_sel = 2'd1; #1;
    chk("R1 cause cleared", rd_data, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule